// File: doc/BRIEF.md
# Indirect Index/Data Register Window

This block is an I/O-port slave that gives a host a narrow, two-port window into a large dword-addressed register space and into a separate translation-table space. The first port, the index port, holds a dword offset together with a two-bit target selector. The second port, the data port, does not store anything. Each access to it becomes one single-dword transaction on a back end, at the offset held in the index.

The block has one request/response channel to the register file and one to the table. Data-port writes go to the back end named by the selector. Data-port reads always go to the register file, whatever the selector holds. The host signals access width through byte enables. A write to the index takes effect only when all four lanes are enabled. Narrow accesses to the data port are passed through with their byte enables. The host sees `host_ready` only after the back end has answered, and at most one back-end transaction is open at any time.

Top module: `idx_data_window`

## Requirements
- R1: After reset the index register reads 00000000h, `host_ready` is low and neither `reg_req` nor `tbl_req` is asserted.
- R2: `host_addr` bit 2 selects the port: 0 is the index port, 1 is the data port. A write to the index port with `host_be` = 1111 loads the whole word, with the offset in bits 31:2 and the selector in bits 1:0. A read of the index port returns the stored word. Either index access raises `host_ready` in the cycle after the strobe.
- R3: A write to the index port with any `host_be` other than 1111 completes with `host_ready` and leaves the index register unchanged.
- R4: A data-port write with selector 00 raises `reg_req` with `reg_we` = 1, `reg_addr` = index bits 31:2 and `reg_wdata` = `host_wdata`. A write with all four lanes enabled carries `reg_be` = 1111.
- R5: A data-port write with selector 01 goes to the table channel (`tbl_req`, `tbl_we` = 1) and not to the register channel. The table channel never carries a read.
- R6: A data-port read with selector 00 or 01 goes to the register channel with `reg_we` = 0, and `host_rdata` returns the dword from `reg_rdata`.
- R7: A narrow data-port read forwards `host_be` as `reg_be`. `host_rdata` returns the enabled byte lanes of the register dword, with disabled lanes at zero (lane i is bits 8i+7:8i).
- R8: A narrow data-port write is forwarded with `reg_be` equal to `host_be`, so only the enabled lanes of the register change.
- R9: A data-port access while the selector is 1x (10 or 11) raises `host_ready` in the next cycle with no back-end request. A read in that case returns FFFFFFFFh.
- R10: A back-end request stays high until its ack. `host_ready` is raised for exactly one cycle, in the cycle after the ack is sampled. The two channels are never requested at the same time.
- R11: The back-end dword address equals index bits 31:2 on every access. It does not advance from one access to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | PORT_AW | Host I/O byte offset; top bit selects index (0) or data (1) |
| host_be | input | DATA_W/8 | Host byte enables |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, valid with host_ready |
| host_ready | output | 1 | One-cycle completion pulse |
| reg_req | output | 1 | Register back-end request, held until ack |
| reg_we | output | 1 | Register back-end write flag |
| reg_addr | output | DATA_W-SEL_W | Register back-end dword address |
| reg_be | output | DATA_W/8 | Register back-end byte enables |
| reg_wdata | output | DATA_W | Register back-end write data |
| reg_ack | input | 1 | Register back-end completion |
| reg_rdata | input | DATA_W | Register back-end read data, valid with ack |
| tbl_req | output | 1 | Table back-end request, held until ack |
| tbl_we | output | 1 | Table back-end write flag |
| tbl_addr | output | DATA_W-SEL_W | Table back-end dword address |
| tbl_be | output | DATA_W/8 | Table back-end byte enables |
| tbl_wdata | output | DATA_W | Table back-end write data |
| tbl_ack | input | 1 | Table back-end completion |

## Verification
The bench builds the block with its defaults: 32-bit data, a 3-bit port address and a 2-bit selector. That gives a 30-bit dword offset, so the bench can load the all-ones offset and confirm that the top offset bit reaches the back end unchanged. The back-end responders answer after a latency of 0 to 3 cycles, set per test. This exercises the hold-until-ack behaviour and puts the completion pulse at several distances from the strobe. Both values of the reserved selector are tried, for reads and for writes.

// File: rtl/idw_pkg.sv
package idw_pkg;
  typedef enum logic {ST_IDLE, ST_WAIT} idw_state_t;

  localparam logic [1:0] TGT_REG = 2'b00;
  localparam logic [1:0] TGT_TBL = 2'b01;

  localparam int CH_REG = 0;
  localparam int CH_TBL = 1;
  localparam int NUM_CH = 2;
endpackage

// File: rtl/idw_decode.sv
module idw_decode #(
  parameter int PORT_AW = 3,
  parameter int BE_W    = 4
) (
  input  logic [PORT_AW-1:0] host_addr,
  input  logic [BE_W-1:0]    host_be,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic               can_take,
  output logic               go,
  output logic               go_wr,
  output logic               at_data,
  output logic               whole
);
  // a write wins if both strobes arrive together
  assign go      = can_take & (host_wr | host_rd);
  assign go_wr   = host_wr;
  assign at_data = host_addr[PORT_AW-1];
  assign whole   = &host_be;
endmodule

// File: rtl/idw_index_reg.sv
module idw_index_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/idw_bechan.sv
module idw_bechan #(
  parameter int AW   = 30,
  parameter int DW   = 32,
  parameter int BE_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            we_in,
  input  logic [AW-1:0]   addr_in,
  input  logic [BE_W-1:0] be_in,
  input  logic [DW-1:0]   wdata_in,
  input  logic            ack,
  output logic            req,
  output logic            we,
  output logic [AW-1:0]   addr,
  output logic [BE_W-1:0] be,
  output logic [DW-1:0]   wdata
);
  always_ff @(posedge clk) begin
    if (rst)        req <= 1'b0;
    else if (start) req <= 1'b1;
    else if (ack)   req <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      we    <= 1'b0;
      addr  <= '0;
      be    <= '0;
      wdata <= '0;
    end else if (start) begin
      we    <= we_in;
      addr  <= addr_in;
      be    <= be_in;
      wdata <= wdata_in;
    end
  end
endmodule

// File: rtl/idx_data_window.sv
module idx_data_window
  import idw_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int PORT_AW = 3,
  parameter int SEL_W   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PORT_AW-1:0]      host_addr,
  input  logic [DATA_W/8-1:0]     host_be,
  input  logic                    host_wr,
  input  logic                    host_rd,
  input  logic [DATA_W-1:0]       host_wdata,
  output logic [DATA_W-1:0]       host_rdata,
  output logic                    host_ready,
  output logic                    reg_req,
  output logic                    reg_we,
  output logic [DATA_W-SEL_W-1:0] reg_addr,
  output logic [DATA_W/8-1:0]     reg_be,
  output logic [DATA_W-1:0]       reg_wdata,
  input  logic                    reg_ack,
  input  logic [DATA_W-1:0]       reg_rdata,
  output logic                    tbl_req,
  output logic                    tbl_we,
  output logic [DATA_W-SEL_W-1:0] tbl_addr,
  output logic [DATA_W/8-1:0]     tbl_be,
  output logic [DATA_W-1:0]       tbl_wdata,
  input  logic                    tbl_ack
);
  localparam int BE_W  = DATA_W / 8;
  localparam int OFF_W = DATA_W - SEL_W;

  idw_state_t st;
  logic       busy;
  assign busy = (st != ST_IDLE);

  // host decode
  logic go, go_wr, at_data, whole;
  idw_decode #(.PORT_AW(PORT_AW), .BE_W(BE_W)) u_dec (
    .host_addr (host_addr),
    .host_be   (host_be),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .can_take  (!busy && !host_ready),
    .go        (go),
    .go_wr     (go_wr),
    .at_data   (at_data),
    .whole     (whole)
  );

  // index register
  logic [DATA_W-1:0] idx_q;
  logic              idx_load;
  assign idx_load = go && !at_data && go_wr && whole;

  idw_index_reg #(.DATA_W(DATA_W)) u_idx (
    .clk  (clk),
    .rst  (rst),
    .load (idx_load),
    .din  (host_wdata),
    .q    (idx_q)
  );

  logic [OFF_W-1:0] idx_off;
  logic [SEL_W-1:0] idx_sel;
  logic             sel_rsv, sel_tbl;
  assign idx_off = idx_q[DATA_W-1:SEL_W];
  assign idx_sel = idx_q[SEL_W-1:0];
  assign sel_rsv = |idx_sel[SEL_W-1:1];
  assign sel_tbl = (idx_sel == SEL_W'(TGT_TBL));

  // back-end channels
  logic [NUM_CH-1:0] ch_start, ch_ack, ch_req, ch_we;
  logic [OFF_W-1:0]  ch_addr  [NUM_CH];
  logic [BE_W-1:0]   ch_be    [NUM_CH];
  logic [DATA_W-1:0] ch_wdata [NUM_CH];

  logic fwd;
  assign fwd = go && at_data && !sel_rsv;
  // reads are steered to the register space whatever the selector says
  assign ch_start[CH_REG] = fwd && (!go_wr || !sel_tbl);
  assign ch_start[CH_TBL] = fwd && go_wr && sel_tbl;
  assign ch_ack[CH_REG]   = reg_ack;
  assign ch_ack[CH_TBL]   = tbl_ack;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    idw_bechan #(.AW(OFF_W), .DW(DATA_W), .BE_W(BE_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .start    (ch_start[ch]),
      .we_in    (go_wr),
      .addr_in  (idx_off),
      .be_in    (host_be),
      .wdata_in (host_wdata),
      .ack      (ch_ack[ch]),
      .req      (ch_req[ch]),
      .we       (ch_we[ch]),
      .addr     (ch_addr[ch]),
      .be       (ch_be[ch]),
      .wdata    (ch_wdata[ch])
    );
  end

  assign reg_req   = ch_req[CH_REG];
  assign reg_we    = ch_we[CH_REG];
  assign reg_addr  = ch_addr[CH_REG];
  assign reg_be    = ch_be[CH_REG];
  assign reg_wdata = ch_wdata[CH_REG];
  assign tbl_req   = ch_req[CH_TBL];
  assign tbl_we    = ch_we[CH_TBL];
  assign tbl_addr  = ch_addr[CH_TBL];
  assign tbl_be    = ch_be[CH_TBL];
  assign tbl_wdata = ch_wdata[CH_TBL];

  // read lane mask from the byte enables of the open read
  logic [BE_W-1:0]   pend_be;
  logic              pend_rd;
  logic [DATA_W-1:0] lane_mask;
  for (genvar ln = 0; ln < BE_W; ln++) begin : g_lane
    assign lane_mask[8*ln +: 8] = {8{pend_be[ln]}};
  end

  logic done;
  assign done = |(ch_req & ch_ack);

  // completion sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      host_ready <= 1'b0;
      host_rdata <= '0;
      pend_be    <= '0;
      pend_rd    <= 1'b0;
    end else begin
      host_ready <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (go) begin
            if (!at_data) begin
              host_ready <= 1'b1;
              if (!go_wr) host_rdata <= idx_q;
            end else if (sel_rsv) begin
              host_ready <= 1'b1;
              if (!go_wr) host_rdata <= '1;
            end else begin
              st      <= ST_WAIT;
              pend_be <= host_be;
              pend_rd <= !go_wr;
            end
          end
        end
        ST_WAIT: begin
          if (done) begin
            st         <= ST_IDLE;
            host_ready <= 1'b1;
            if (pend_rd) host_rdata <= reg_rdata & lane_mask;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idw_window_chk.sv
module idw_window_chk #(
  parameter int DATA_W  = 32,
  parameter int PORT_AW = 3,
  parameter int SEL_W   = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic [PORT_AW-1:0]      host_addr,
  input logic [DATA_W/8-1:0]     host_be,
  input logic                    host_wr,
  input logic                    host_rd,
  input logic                    host_ready,
  input logic                    busy,
  input logic [DATA_W-1:0]       idx_q,
  input logic                    reg_req,
  input logic                    reg_ack,
  input logic [DATA_W-SEL_W-1:0] reg_addr,
  input logic                    tbl_req,
  input logic                    tbl_we,
  input logic                    tbl_ack
);
  logic taken;
  assign taken = (host_wr || host_rd) && !busy && !host_ready;

  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (rst)
    !(reg_req && tbl_req));

  assert_reg_req_held_R10: assert property (@(posedge clk) disable iff (rst)
    reg_req && !reg_ack |=> reg_req);

  assert_tbl_req_held_R10: assert property (@(posedge clk) disable iff (rst)
    tbl_req && !tbl_ack |=> tbl_req);

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    host_ready |=> !host_ready);

  assert_ready_waits_ack_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_req && !reg_ack) || (tbl_req && !tbl_ack) |=> !host_ready);

  assert_tbl_write_only_R5: assert property (@(posedge clk) disable iff (rst)
    tbl_req |-> tbl_we);

  assert_partial_index_keeps_R3: assert property (@(posedge clk) disable iff (rst)
    taken && host_wr && !host_addr[PORT_AW-1] && !(&host_be) |=> $stable(idx_q));

  assert_addr_is_offset_R11: assert property (@(posedge clk) disable iff (rst)
    reg_req |-> reg_addr == idx_q[DATA_W-1:SEL_W]);

  assert_reserved_silent_R9: assert property (@(posedge clk) disable iff (rst)
    taken && host_addr[PORT_AW-1] && idx_q[SEL_W-1] |=> !reg_req && !tbl_req && host_ready);
endmodule

bind idx_data_window idw_window_chk #(
  .DATA_W(DATA_W), .PORT_AW(PORT_AW), .SEL_W(SEL_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_addr  (host_addr),
  .host_be    (host_be),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_ready (host_ready),
  .busy       (busy),
  .idx_q      (idx_q),
  .reg_req    (reg_req),
  .reg_ack    (reg_ack),
  .reg_addr   (reg_addr),
  .tbl_req    (tbl_req),
  .tbl_we     (tbl_we),
  .tbl_ack    (tbl_ack)
);

// File: tb/test_idx_data_window.sv
module test_idx_data_window;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic [2:0]  host_addr;
  logic [3:0]  host_be;
  logic        host_wr, host_rd;
  logic [31:0] host_wdata, host_rdata;
  logic        host_ready;
  logic        reg_req, reg_we, reg_ack;
  logic [29:0] reg_addr;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata, reg_rdata;
  logic        tbl_req, tbl_we, tbl_ack;
  logic [29:0] tbl_addr;
  logic [3:0]  tbl_be;
  logic [31:0] tbl_wdata;

  idx_data_window i_idx_data_window (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_be(host_be),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_ready(host_ready),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
    .tbl_req(tbl_req), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_be(tbl_be),
    .tbl_wdata(tbl_wdata), .tbl_ack(tbl_ack)
  );

  int    checks = 0;
  int    fails  = 0;
  string cur_tag = "R1";

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // back-end storage models
  logic [31:0] regmem [int];
  logic [31:0] tblmem [int];

  function automatic logic [31:0] seed_val(input int a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] rd_reg(input int a);
    return regmem.exists(a) ? regmem[a] : seed_val(a);
  endfunction

  function automatic logic [31:0] lanes(input logic [31:0] v, input logic [3:0] be);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = v[8*i +: 8];
    return r;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  // responders: ack after lat_cfg idle cycles
  int lat_cfg = 0;
  int reg_cnt, tbl_cnt;
  bit reg_cnt_on, tbl_cnt_on;
  int n_reg = 0, n_tbl = 0;
  logic [29:0] last_reg_addr;
  logic [3:0]  last_reg_be;

  always @(negedge clk) begin
    if (rst) begin
      reg_ack = 1'b0; tbl_ack = 1'b0; reg_rdata = '0;
      reg_cnt_on = 0; tbl_cnt_on = 0;
    end else begin
      if (reg_ack) reg_ack = 1'b0;
      else if (reg_req) begin
        if (!reg_cnt_on) begin reg_cnt = lat_cfg; reg_cnt_on = 1; end
        if (reg_cnt == 0) begin
          reg_ack = 1'b1; reg_cnt_on = 0; n_reg++;
          last_reg_addr = reg_addr; last_reg_be = reg_be;
          if (reg_we) regmem[int'(reg_addr)] = merge(rd_reg(int'(reg_addr)), reg_wdata, reg_be);
          else reg_rdata = rd_reg(int'(reg_addr));
        end else reg_cnt--;
      end
      if (tbl_ack) tbl_ack = 1'b0;
      else if (tbl_req) begin
        if (!tbl_cnt_on) begin tbl_cnt = lat_cfg; tbl_cnt_on = 1; end
        if (tbl_cnt == 0) begin
          tbl_ack = 1'b1; tbl_cnt_on = 0; n_tbl++;
          tblmem[int'(tbl_addr)] = tbl_wdata;
        end else tbl_cnt--;
      end
    end
  end

  // cycle reference model
  logic [31:0] mindex, mrdata, mwdata;
  logic [29:0] maddr;
  logic [3:0]  mbe;
  bit mbusy, mrd, mrd_done, mready, mreg_pend, mtbl_pend, nr;

  always @(posedge clk) begin
    if (rst) begin
      mindex = '0; mbusy = 0; mready = 0; mreg_pend = 0; mtbl_pend = 0; mrd_done = 0;
    end else begin
      nr = 0;
      if (mbusy) begin
        if ((mreg_pend && reg_ack) || (mtbl_pend && tbl_ack)) begin
          if (mreg_pend) begin
            chk(reg_addr == maddr, "R11", "reg_addr", 64'(reg_addr), 64'(maddr));
            chk(reg_be == mbe, "R8", "reg_be", 64'(reg_be), 64'(mbe));
            chk(reg_we == !mrd, "R4", "reg_we", 64'(reg_we), 64'(!mrd));
            if (!mrd) chk(reg_wdata == mwdata, "R4", "reg_wdata", 64'(reg_wdata), 64'(mwdata));
          end else begin
            chk(tbl_addr == maddr && tbl_wdata == mwdata, "R5", "tbl addr/data",
                {2'b0, tbl_addr, tbl_wdata}, {2'b0, maddr, mwdata});
          end
          nr = 1; mrd_done = mrd;
          if (mrd) mrdata = lanes(rd_reg(int'(maddr)), mbe);
          mreg_pend = 0; mtbl_pend = 0; mbusy = 0;
        end
      end else if ((host_wr || host_rd) && !mready) begin
        mrd_done = 0;
        if (!host_addr[2]) begin
          nr = 1;
          if (host_wr && host_be == 4'hF) mindex = host_wdata;
          if (!host_wr) begin mrdata = mindex; mrd_done = 1; end
        end else if (mindex[1]) begin
          nr = 1;
          if (!host_wr) begin mrdata = '1; mrd_done = 1; end
        end else begin
          mbusy = 1; mrd = !host_wr; maddr = mindex[31:2]; mbe = host_be; mwdata = host_wdata;
          if (host_wr && mindex[1:0] == 2'b01) mtbl_pend = 1; else mreg_pend = 1;
        end
      end
      mready = nr;
    end
  end

  // compare on every clock
  always @(negedge clk) begin
    if (!rst) begin
      chk(reg_req == mreg_pend && tbl_req == mtbl_pend && host_ready == mready,
          "R10", "req/ready per cycle", {reg_req, tbl_req, host_ready},
          {mreg_pend, mtbl_pend, mready});
      if (mready && mrd_done)
        chk(host_rdata == mrdata, cur_tag, "host_rdata per cycle", 64'(host_rdata), 64'(mrdata));
    end
  end

  task automatic access(input bit data_port, input logic [3:0] be, input bit wr,
                        input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    host_addr = data_port ? 3'd4 : 3'd0; host_be = be;
    host_wr = wr; host_rd = !wr; host_wdata = wd;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0; cyc = 1;
    while (!host_ready && cyc < 50) begin @(negedge clk); cyc++; end
    rd = host_rdata;
    if (cyc >= 50) chk(0, cur_tag, "access timeout", 64'(cyc), 64'd0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R10", "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int cyc, r0, t0;
    rst = 1'b1; host_addr = '0; host_be = '0; host_wr = 0; host_rd = 0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    cur_tag = "R1";
    @(negedge clk);
    chk(!host_ready && !reg_req && !tbl_req, "R1", "idle outputs after reset",
        {host_ready, reg_req, tbl_req}, 0);
    access(0, 4'hF, 0, 0, rd, cyc);
    chk(rd == 32'h0, "R1", "index reset value", 64'(rd), 0);

    cur_tag = "R2";
    access(0, 4'hF, 1, 32'h0000_48D0, rd, cyc);
    chk(cyc == 1, "R2", "index write latency", 64'(cyc), 1);
    access(0, 4'hF, 0, 0, rd, cyc);
    chk(rd == 32'h0000_48D0 && cyc == 1, "R2", "index readback", 64'(rd), 64'h48D0);

    cur_tag = "R3";
    access(0, 4'b0011, 1, 32'hFFFF_FFFF, rd, cyc);
    chk(cyc == 1, "R3", "partial index write acknowledged", 64'(cyc), 1);
    access(0, 4'b0001, 1, 32'hFFFF_FFFF, rd, cyc);
    access(0, 4'hF, 0, 0, rd, cyc);
    chk(rd == 32'h0000_48D0, "R3", "index unchanged by narrow write", 64'(rd), 64'h48D0);

    cur_tag = "R4";
    lat_cfg = 0; r0 = n_reg; t0 = n_tbl;
    access(1, 4'hF, 1, 32'hCAFE_0001, rd, cyc);
    chk(cyc == 2, "R4", "write latency at lat 0", 64'(cyc), 2);
    chk(n_reg == r0 + 1 && n_tbl == t0, "R4", "register write count", 64'(n_reg - r0), 1);
    chk(last_reg_addr == 30'h1234 && last_reg_be == 4'hF, "R4", "addr/be",
        {last_reg_addr, last_reg_be}, {30'h1234, 4'hF});

    cur_tag = "R6";
    access(1, 4'hF, 0, 0, rd, cyc);
    chk(rd == 32'hCAFE_0001, "R6", "data read sel 00", 64'(rd), 64'hCAFE0001);

    cur_tag = "R5";
    access(0, 4'hF, 1, {30'h77, 2'b01}, rd, cyc);
    lat_cfg = 2; r0 = n_reg; t0 = n_tbl;
    access(1, 4'hF, 1, 32'hDEAD_BEEF, rd, cyc);
    chk(n_tbl == t0 + 1 && n_reg == r0, "R5", "write goes to table", 64'(n_tbl - t0), 1);
    chk(tblmem.exists(32'h77) && tblmem[32'h77] == 32'hDEAD_BEEF, "R5", "table contents",
        64'(tblmem[32'h77]), 64'hDEADBEEF);
    chk(cyc == 4, "R10", "write latency at lat 2", 64'(cyc), 4);

    cur_tag = "R6";
    r0 = n_reg; t0 = n_tbl;
    access(1, 4'hF, 0, 0, rd, cyc);
    chk(n_reg == r0 + 1 && n_tbl == t0, "R6", "sel 01 read goes to registers", 64'(n_reg - r0), 1);
    chk(rd == seed_val(32'h77), "R6", "sel 01 read data", 64'(rd), 64'(seed_val(32'h77)));

    cur_tag = "R7";
    lat_cfg = 1;
    access(0, 4'hF, 1, {30'h1234, 2'b00}, rd, cyc);
    access(1, 4'b0100, 0, 0, rd, cyc);
    chk(rd == 32'h00FE_0000 && last_reg_be == 4'b0100, "R7", "byte lane 2 read",
        64'(rd), 64'h00FE0000);
    access(1, 4'b1100, 0, 0, rd, cyc);
    chk(rd == 32'hCAFE_0000, "R7", "upper half read", 64'(rd), 64'hCAFE0000);

    cur_tag = "R8";
    access(1, 4'b0010, 1, 32'h1111_5511, rd, cyc);
    chk(last_reg_be == 4'b0010, "R8", "narrow write be", 64'(last_reg_be), 2);
    access(1, 4'hF, 0, 0, rd, cyc);
    chk(rd == 32'hCAFE_5501, "R8", "only lane 1 written", 64'(rd), 64'hCAFE5501);

    cur_tag = "R9";
    for (int s = 2; s < 4; s++) begin
      access(0, 4'hF, 1, {30'h55, 2'(s)}, rd, cyc);
      r0 = n_reg; t0 = n_tbl;
      access(1, 4'hF, 0, 0, rd, cyc);
      chk(rd == 32'hFFFF_FFFF && cyc == 1, "R9", "reserved read", 64'(rd), 64'hFFFFFFFF);
      access(1, 4'hF, 1, 32'h0BAD_0BAD, rd, cyc);
      chk(n_reg == r0 && n_tbl == t0 && cyc == 1, "R9", "reserved no transaction",
          64'(n_reg - r0 + n_tbl - t0), 0);
    end
    access(0, 4'hF, 1, {30'h55, 2'b00}, rd, cyc);
    access(1, 4'hF, 0, 0, rd, cyc);
    chk(rd == seed_val(32'h55), "R9", "register untouched by reserved write",
        64'(rd), 64'(seed_val(32'h55)));

    cur_tag = "R10";
    lat_cfg = 3;
    access(1, 4'hF, 0, 0, rd, cyc);
    chk(cyc == 5, "R10", "ready after ack at lat 3", 64'(cyc), 5);

    cur_tag = "R11";
    lat_cfg = 0;
    access(0, 4'hF, 1, {30'h3FFF_FFFF, 2'b00}, rd, cyc);
    access(1, 4'hF, 1, 32'h1357_9BDF, rd, cyc);
    access(1, 4'hF, 1, 32'h2468_ACE0, rd, cyc);
    chk(last_reg_addr == 30'h3FFF_FFFF, "R11", "no increment", 64'(last_reg_addr), 64'h3FFFFFFF);
    access(1, 4'hF, 0, 0, rd, cyc);
    chk(rd == 32'h2468_ACE0, "R11", "second write same dword", 64'(rd), 64'h2468ACE0);
    access(0, 4'hF, 0, 0, rd, cyc);
    chk(rd == 32'hFFFF_FFFC, "R11", "index unchanged", 64'(rd), 64'hFFFFFFFC);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule